// File: doc/BRIEF.md
# Removable Memory Card Access Decoder

This block sits between the host-side control pins of a 16-bit removable memory card and its internal storage. It turns two active-low card enables, an output strobe, a write strobe, a register-space select, address bit zero and the upper address bit into chip selects for four flash segments and one attribute memory. The four flash segments form two pairs, each with an even and an odd member. It also produces enables and a direction control for the low and high data-byte transceivers, and a steering flag that moves odd bytes onto the low lane.

Each cycle the decoder samples the pins. A small state machine classifies the access, and every output comes from registers, so outputs follow the sampled pins by exactly one clock. The machine has these states:

- `ST_STANDBY`: no enable is asserted.
- `ST_ARMED`: the card is enabled but neither strobe is active.
- `ST_READ`: the card drives the host.
- `ST_WRITE`: a write strobe reaches the storage.
- `ST_REJECT`: a write is refused because of write protect, a low output strobe, or an odd attribute address.

Transitions:

- `go_standby`: both enables are high.
- `go_write`: the write strobe is low, the output strobe is high, write protect is off and the address is valid.
- `go_reject`: the write strobe is low and any of those conditions fails.
- `go_read`: only the output strobe is low.
- `go_armed`: the card is enabled with no strobe.

Every transition is evaluated from any state.

Top module: `card_access_decoder`

## Requirements
- R1: Low-byte mode (`ce_lo_n`=0, `ce_hi_n`=1) selects segment index 2*`addr_top`+`addr_lsb`. Only `lane_lo_en` is enabled. `odd_to_low` equals `addr_lsb`.
- R2: Word mode (both enables 0) selects both segments of the addressed pair, 2*`addr_top` and 2*`addr_top`+1. It enables both lanes and ignores `addr_lsb`.
- R3: `addr_top` picks the pair. Segment bit s belongs to pair s/2 and is the odd member when s is odd.
- R4: With both enables high, all of these are 0: `seg_cs`, `attr_cs`, both lane enables, `odd_to_low`, `card_drive` and `wr_strobe`.
- R5: `card_drive` is 1 only when the card is enabled, `oe_n`=0 and `we_n`=1.
- R6: With `reg_n`=0, no flash segment is selected and only the low lane is enabled. `attr_cs` is 1 only for even addresses. A write to an odd attribute address produces no `wr_strobe`.
- R7: With `wp_sw`=1, `wr_strobe` stays 0 and no segment or lane is opened for a write. `wp_status` follows `wp_sw`.
- R8: `we_n`=0 together with `oe_n`=0 is ignored: no selects, no lanes, no drive and no strobe.
- R9: High-byte mode (`ce_lo_n`=1, `ce_hi_n`=0) selects only the odd segment of the pair. It enables only `lane_hi_en`, with `odd_to_low`=0.
- R10: Outputs reflect the pins sampled at the previous rising clock edge. During reset all outputs are 0.
- R11: Selects and lanes are open only for a read or an accepted write. With the card enabled and both strobes high, they are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_lo_n | input | 1 | Active-low enable for the low byte |
| ce_hi_n | input | 1 | Active-low enable for the high byte |
| oe_n | input | 1 | Active-low output strobe |
| we_n | input | 1 | Active-low write strobe |
| reg_n | input | 1 | Low selects attribute space |
| addr_lsb | input | 1 | Address bit zero (even/odd) |
| addr_top | input | PAIR_BITS | Upper address bits selecting the segment pair |
| wp_sw | input | 1 | Write-protect switch, active high |
| seg_cs | output | NUM_SEG | Active-high flash segment selects |
| attr_cs | output | 1 | Active-high attribute memory select |
| lane_lo_en | output | 1 | Low data-byte transceiver enable |
| lane_hi_en | output | 1 | High data-byte transceiver enable |
| odd_to_low | output | 1 | Route the odd segment onto the low lane |
| card_drive | output | 1 | Transceiver direction, 1 = card to host |
| wr_strobe | output | 1 | Internal write strobe to storage |
| wp_status | output | 1 | Registered write-protect status |

## Verification
The bench goes after these corner cases:

- **Odd byte in low-byte mode.** A decoder that forgot the steering flag would return the odd byte on the wrong lane.
- **High-byte-only access.** A decoder that chose the segment by `addr_lsb` here would select the even segment.
- **Odd attribute writes.** A decoder that let these through would corrupt the attribute memory.
- **Simultaneous low output and write strobes.** Mishandling these would drive the bus while a write is latched.

Write protect is exercised in word mode and in byte mode, where a leak would show as a strobe or an opened segment. Finally, every one of the 256 combinations of the control pins is swept. This catches any pair-index or latency slip, which would show as a wrong or late segment bit.

// File: rtl/card_dec_pkg.sv
package card_dec_pkg;

    typedef enum logic [1:0] {
        W_OFF,
        W_BYTE_LO,
        W_BYTE_HI,
        W_WORD
    } width_e;

    typedef enum logic [2:0] {
        ST_STANDBY,
        ST_ARMED,
        ST_READ,
        ST_WRITE,
        ST_REJECT
    } acc_state_e;

endpackage

// File: rtl/card_width_decode.sv
module card_width_decode
    import card_dec_pkg::*;
#(
    parameter int PAIR_BITS = 1,
    localparam int NUM_SEG = 2 * (1 << PAIR_BITS)
) (
    input  logic                 ce_lo_n,
    input  logic                 ce_hi_n,
    input  logic                 reg_n,
    input  logic                 addr_lsb,
    input  logic [PAIR_BITS-1:0] addr_top,
    output logic                 enabled,
    output logic                 attr_odd,
    output logic [NUM_SEG-1:0]   seg_req,
    output logic                 lane_lo_req,
    output logic                 lane_hi_req,
    output logic                 swap_req,
    output logic                 attr_req
);

    width_e width;
    logic   attr_space;

    assign attr_space = !reg_n;

    // Width mode from the pair of enables
    always_comb begin
        unique case ({ce_hi_n, ce_lo_n})
            2'b10:   width = W_BYTE_LO;
            2'b01:   width = W_BYTE_HI;
            2'b00:   width = W_WORD;
            default: width = W_OFF;
        endcase
    end

    assign enabled  = (width != W_OFF);
    assign attr_odd = attr_space && addr_lsb;
    assign attr_req = attr_space && enabled && !addr_lsb;

    // Lane steering
    always_comb begin
        if (attr_space) begin
            lane_lo_req = enabled;
            lane_hi_req = 1'b0;
            swap_req    = 1'b0;
        end else begin
            lane_lo_req = (width == W_BYTE_LO) || (width == W_WORD);
            lane_hi_req = (width == W_BYTE_HI) || (width == W_WORD);
            swap_req    = (width == W_BYTE_LO) && addr_lsb;
        end
    end

    // One select decoder per flash segment
    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        localparam logic [PAIR_BITS-1:0] SEG_PAIR = PAIR_BITS'(s >> 1);
        localparam logic SEG_ODD = 1'((s & 1) != 0);
        logic lane_hit;

        always_comb begin
            unique case (width)
                W_BYTE_LO: lane_hit = (addr_lsb == SEG_ODD);
                W_BYTE_HI: lane_hit = SEG_ODD;
                W_WORD:    lane_hit = 1'b1;
                default:   lane_hit = 1'b0;
            endcase
        end

        assign seg_req[s] = !attr_space && (addr_top == SEG_PAIR) && lane_hit;
    end

endmodule

// File: rtl/card_access_fsm.sv
module card_access_fsm
    import card_dec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enabled,
    input  logic oe_n,
    input  logic we_n,
    input  logic wp_sw,
    input  logic attr_odd,
    output logic open_d,
    output logic card_drive,
    output logic wr_strobe
);

    acc_state_e state_q, state_d;

    // Next-state selection
    always_comb begin
        if (!enabled) begin
            state_d = ST_STANDBY;                       // go_standby
        end else if (!we_n) begin
            if (oe_n && !wp_sw && !attr_odd)
                state_d = ST_WRITE;                     // go_write
            else
                state_d = ST_REJECT;                    // go_reject
        end else if (!oe_n) begin
            state_d = ST_READ;                          // go_read
        end else begin
            state_d = ST_ARMED;                         // go_armed
        end
    end

    assign open_d = (state_d == ST_READ) || (state_d == ST_WRITE);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STANDBY;
        else        state_q <= state_d;
    end

    // Outputs from the registered state
    always_comb begin
        card_drive = 1'b0;
        wr_strobe  = 1'b0;
        unique case (state_q)
            ST_READ:  card_drive = 1'b1;
            ST_WRITE: wr_strobe  = 1'b1;
            ST_STANDBY, ST_ARMED, ST_REJECT: ;
            default: ;
        endcase
    end

    p_wp_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wp_sw) |-> !wr_strobe);

    p_oe_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!oe_n && !we_n) |-> (!wr_strobe && !card_drive));

    p_drive_needs_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        card_drive |-> $past(!oe_n && we_n && enabled));

    p_standby_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!enabled) |-> (state_q == ST_STANDBY));

endmodule

// File: rtl/card_out_stage.sv
module card_out_stage #(
    parameter int NUM_SEG = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               open_d,
    input  logic [NUM_SEG-1:0] seg_req,
    input  logic               lane_lo_req,
    input  logic               lane_hi_req,
    input  logic               swap_req,
    input  logic               attr_req,
    input  logic               wp_sw,
    output logic [NUM_SEG-1:0] seg_cs,
    output logic               attr_cs,
    output logic               lane_lo_en,
    output logic               lane_hi_en,
    output logic               odd_to_low,
    output logic               wp_status
);

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_cs
        always_ff @(posedge clk) begin
            if (!rst_n) seg_cs[s] <= 1'b0;
            else        seg_cs[s] <= open_d && seg_req[s];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attr_cs    <= 1'b0;
            lane_lo_en <= 1'b0;
            lane_hi_en <= 1'b0;
            odd_to_low <= 1'b0;
            wp_status  <= 1'b0;
        end else begin
            attr_cs    <= open_d && attr_req;
            lane_lo_en <= open_d && lane_lo_req;
            lane_hi_en <= open_d && lane_hi_req;
            odd_to_low <= open_d && swap_req;
            wp_status  <= wp_sw;
        end
    end

    p_seg_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seg_cs) <= 2);

    p_byte_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_lo_en != lane_hi_en) |-> $onehot0(seg_cs));

    p_attr_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        attr_cs |-> (seg_cs == '0 && !lane_hi_en));

    p_closed_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!open_d) |-> (seg_cs == '0 && !lane_lo_en && !lane_hi_en && !attr_cs));

endmodule

// File: rtl/card_access_decoder.sv
module card_access_decoder #(
    parameter int PAIR_BITS = 1,
    localparam int NUM_SEG = 2 * (1 << PAIR_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce_lo_n,
    input  logic                 ce_hi_n,
    input  logic                 oe_n,
    input  logic                 we_n,
    input  logic                 reg_n,
    input  logic                 addr_lsb,
    input  logic [PAIR_BITS-1:0] addr_top,
    input  logic                 wp_sw,
    output logic [NUM_SEG-1:0]   seg_cs,
    output logic                 attr_cs,
    output logic                 lane_lo_en,
    output logic                 lane_hi_en,
    output logic                 odd_to_low,
    output logic                 card_drive,
    output logic                 wr_strobe,
    output logic                 wp_status
);

    logic               enabled;
    logic               attr_odd;
    logic [NUM_SEG-1:0] seg_req;
    logic               lane_lo_req;
    logic               lane_hi_req;
    logic               swap_req;
    logic               attr_req;
    logic               open_d;

    card_width_decode #(.PAIR_BITS(PAIR_BITS)) i_decode (
        .ce_lo_n     (ce_lo_n),
        .ce_hi_n     (ce_hi_n),
        .reg_n       (reg_n),
        .addr_lsb    (addr_lsb),
        .addr_top    (addr_top),
        .enabled     (enabled),
        .attr_odd    (attr_odd),
        .seg_req     (seg_req),
        .lane_lo_req (lane_lo_req),
        .lane_hi_req (lane_hi_req),
        .swap_req    (swap_req),
        .attr_req    (attr_req)
    );

    card_access_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enabled    (enabled),
        .oe_n       (oe_n),
        .we_n       (we_n),
        .wp_sw      (wp_sw),
        .attr_odd   (attr_odd),
        .open_d     (open_d),
        .card_drive (card_drive),
        .wr_strobe  (wr_strobe)
    );

    card_out_stage #(.NUM_SEG(NUM_SEG)) i_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .open_d      (open_d),
        .seg_req     (seg_req),
        .lane_lo_req (lane_lo_req),
        .lane_hi_req (lane_hi_req),
        .swap_req    (swap_req),
        .attr_req    (attr_req),
        .wp_sw       (wp_sw),
        .seg_cs      (seg_cs),
        .attr_cs     (attr_cs),
        .lane_lo_en  (lane_lo_en),
        .lane_hi_en  (lane_hi_en),
        .odd_to_low  (odd_to_low),
        .wp_status   (wp_status)
    );

    p_write_selects_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> (seg_cs != '0 || attr_cs));

endmodule

// File: tb/test_card_access_decoder.sv
module test_card_access_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_lo_n = 1'b1, ce_hi_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic       reg_n = 1'b1, addr_lsb = 1'b0, wp_sw = 1'b0;
    logic [0:0] addr_top = 1'b0;
    logic [3:0] seg_cs;
    logic       attr_cs, lane_lo_en, lane_hi_en, odd_to_low;
    logic       card_drive, wr_strobe, wp_status;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [10:0] exp;
        string       req;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    card_access_decoder i_card_access_decoder (
        .clk(clk), .rst_n(rst_n), .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n),
        .oe_n(oe_n), .we_n(we_n), .reg_n(reg_n), .addr_lsb(addr_lsb),
        .addr_top(addr_top), .wp_sw(wp_sw), .seg_cs(seg_cs), .attr_cs(attr_cs),
        .lane_lo_en(lane_lo_en), .lane_hi_en(lane_hi_en), .odd_to_low(odd_to_low),
        .card_drive(card_drive), .wr_strobe(wr_strobe), .wp_status(wp_status)
    );

    function automatic logic [10:0] observed();
        return {seg_cs, attr_cs, lane_lo_en, lane_hi_en, odd_to_low,
                card_drive, wr_strobe, wp_status};
    endfunction

    // Expected outputs from the requirements:
    // {seg[3:0], attr, lo, hi, swap, drive, strobe, wp}
    function automatic logic [10:0] model(logic c1, logic c2, logic oe, logic we,
                                          logic rg, logic a0, logic top, logic wp);
        logic [3:0] seg = 4'b0;
        logic attr = 0, lo = 0, hi = 0, sw = 0, drv = 0, stb = 0;
        logic en  = !c1 || !c2;
        logic rd  = !oe && we;
        logic wr  = !we && oe && !wp && !(!rg && a0);
        if (en && (rd || wr)) begin
            drv = rd;
            stb = wr;
            if (!rg) begin
                attr = !a0;
                lo   = 1'b1;
            end else if (!c1 && !c2) begin
                seg[2*top]   = 1'b1;
                seg[2*top+1] = 1'b1;
                lo = 1'b1;
                hi = 1'b1;
            end else if (!c1) begin
                seg[2*top+a0] = 1'b1;
                lo = 1'b1;
                sw = a0;
            end else begin
                seg[2*top+1] = 1'b1;
                hi = 1'b1;
            end
        end
        return {seg, attr, lo, hi, sw, drv, stb, wp};
    endfunction

    // Driver: apply pins at a falling edge, queue the expectation
    task automatic apply(logic c1, logic c2, logic oe, logic we, logic rg,
                         logic a0, logic top, logic wp, string req);
        item_t it;
        @(negedge clk);
        ce_lo_n = c1; ce_hi_n = c2; oe_n = oe; we_n = we;
        reg_n = rg; addr_lsb = a0; addr_top = top; wp_sw = wp;
        it.exp = model(c1, c2, oe, we, rg, a0, top, wp);
        it.req = req;
        sb_q.push_back(it);
    endtask

    // Monitor: one rising edge after the drive, compare
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (observed() !== it.exp) begin
                fails++;
                $display("FAIL %s actual=%b expected=%b", it.req, observed(), it.exp);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (observed() !== 11'b0) begin
            fails++;
            $display("FAIL R10 reset actual=%b expected=%b", observed(), 11'b0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1: low-byte mode, even then odd, both pairs
        apply(0, 1, 0, 1, 1, 0, 0, 0, "R1 even read pair0");
        apply(0, 1, 0, 1, 1, 1, 0, 0, "R1 odd read steered low");
        apply(0, 1, 1, 0, 1, 1, 1, 0, "R1 R3 odd write pair1");
        // R2: word mode ignores addr_lsb
        apply(0, 0, 0, 1, 1, 0, 1, 0, "R2 word read pair1");
        apply(0, 0, 0, 1, 1, 1, 1, 0, "R2 word read a0 ignored");
        apply(0, 0, 1, 0, 1, 1, 0, 0, "R2 R3 word write pair0");
        // R9: high-byte only
        apply(1, 0, 0, 1, 1, 0, 0, 0, "R9 high byte read a0=0");
        apply(1, 0, 1, 0, 1, 1, 1, 0, "R9 high byte write pair1");
        // R4 standby
        apply(1, 1, 0, 1, 1, 0, 0, 0, "R4 standby with oe low");
        apply(1, 1, 1, 0, 1, 1, 1, 0, "R4 standby with we low");
        // R11 / R5 enabled, no strobe
        apply(0, 0, 1, 1, 1, 0, 0, 0, "R11 R5 armed no drive");
        // R6 attribute space
        apply(0, 1, 0, 1, 0, 0, 0, 0, "R6 attr even read");
        apply(0, 1, 0, 1, 0, 1, 0, 0, "R6 attr odd read no select");
        apply(0, 1, 1, 0, 0, 1, 1, 0, "R6 attr odd write dropped");
        apply(0, 0, 1, 0, 0, 0, 1, 0, "R6 attr word even write low lane only");
        // R7 write protect
        apply(0, 0, 1, 0, 1, 0, 0, 1, "R7 wp blocks word write");
        apply(0, 1, 1, 0, 1, 1, 1, 1, "R7 wp blocks byte write");
        apply(0, 1, 0, 1, 1, 0, 1, 1, "R7 wp read allowed status high");
        // R8 both strobes low
        apply(0, 0, 0, 0, 1, 0, 0, 0, "R8 oe and we low ignored");
        apply(0, 1, 0, 0, 0, 0, 0, 0, "R8 attr oe and we low ignored");
        // R10 exhaustive sweep back to back
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b;
            b = 8'(v);
            apply(b[7], b[6], b[5], b[4], b[3], b[2], b[1], b[0], "R10 R3 sweep");
        end
        apply(1, 1, 1, 1, 1, 0, 0, 0, "R4 final standby");
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule